// File: doc/BRIEF.md
# Key-Protected Register Bank with Read Parity

This block is a bank of 16-bit registers behind a plain word-wide access port. A serial front end, or any other decoder that delivers complete frames, drives the port one word at a time. The bank holds three kinds of entries. Status words show live flag inputs from elsewhere in the chip and cannot be written. Configuration words are writable, and their values go out as parallel outputs. A command word pulses a one-cycle fault-clear strobe.

A system control word sits on top of these. It holds a lock flag and a parity-enable flag, and it accepts a write only when that write carries a 3-bit key. While the lock flag is set, the configuration words do not change. The control word itself stays reachable with the key, so the lock can always be released. When parity is enabled, bit 15 of every word returned on a read is replaced by a computed parity bit, and the full 16-bit word then has even parity.

Read data is registered and appears one cycle after the read request. It keeps its value until the next read.

Top module: `guarded_regbank`

## Requirements
- R1: After reset the configuration words read 0x0115 at address 0x10, 0x0000 at 0x11 and 0x0777 at 0x12. The system control word at 0x1F reads 0x0000. `lock_o`, `par_en_o`, `clr_pulse_o` and `rdata` are 0.
- R2: A write to a configuration word stores only its implemented bits: mask 0x01FF at 0x10, 0x0FFF at 0x11 and 0x0777 at 0x12. The other bits read as 0. `cfg_o` carries word 0x10 in bits 15:0, 0x11 in bits 31:16 and 0x12 in bits 47:32.
- R3: Address 0x00 reads `stat_dev_i` in bits 6:0. Address 0x01 reads `stat_temp_i` in bits 2:0. Address 0x02 reads `stat_drv_i` in bits 5:0. All bits above these fields read 0, except bit 7 of address 0x00 (see R7).
- R4: Addresses with no register read 0x0000. Writes to them change no register.
- R5: A write to 0x1F takes effect only when `wdata[14:12]` equals 3'b101. Bit 7 of the word is the lock flag and bit 6 is the parity-enable flag. The key field and every other bit of 0x1F read as 0.
- R6: While `lock_o` is 1, writes to configuration words are ignored. Writes to 0x1F with the key still take effect, so the lock can be cleared.
- R7: Address 0x00 bit 7 is a power-on flag that is 1 after reset. Writing 1 to bit 0 of address 0x18 raises `clr_pulse_o` for exactly one cycle, starting the cycle after the write, and clears the power-on flag. This works whether or not the bank is locked. Address 0x18 always reads 0.
- R8: When parity is enabled at the time of a read, `rdata[15]` equals the XOR of `rdata[14:0]`. When parity is disabled, `rdata[15]` is 0.
- R9: `rdata` updates on the clock edge that samples `rd_en` high and holds its value in every cycle without a read.
- R10: Writes to the status words at 0x00 to 0x02 have no effect on what they read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request for this cycle |
| rd_en | input | 1 | Read request for this cycle |
| addr | input | 6 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid the cycle after `rd_en` |
| stat_dev_i | input | 7 | Live device flags shown at 0x00 |
| stat_temp_i | input | 3 | Live temperature flags shown at 0x01 |
| stat_drv_i | input | 6 | Live driver overcurrent flags shown at 0x02 |
| cfg_o | output | 48 | The three configuration words, concatenated |
| lock_o | output | 1 | Lock flag from the control word |
| par_en_o | output | 1 | Parity-enable flag from the control word |
| clr_pulse_o | output | 1 | One-cycle fault-clear strobe |

## Verification
Configuration writes use all-ones and mixed data patterns, so masking of reserved bits is separated from plain storage. Control-word writes are tried with a zero key and with the correct key, and configuration writes are tried locked and unlocked; this separates the key check from the lock check. Reads are repeated with parity on and off, over words with odd and even bit counts, so a wrong parity sense or a missing parity bit shows up. Status inputs are changed between reads to show that the data is live while `rdata` holds between reads.

// File: rtl/grb_pkg.sv
package grb_pkg;
  localparam int DW      = 16;
  localparam int AW      = 6;
  localparam int NUM_CFG = 3;
  localparam int DEV_W   = 7;
  localparam int TEMP_W  = 3;
  localparam int DRV_W   = 6;

  typedef logic [DW-1:0] word_t;
  typedef logic [AW-1:0] addr_t;

  localparam addr_t ADR_DEV  = 6'h00;
  localparam addr_t ADR_TEMP = 6'h01;
  localparam addr_t ADR_DRV  = 6'h02;
  localparam addr_t ADR_CMD  = 6'h18;
  localparam addr_t ADR_SYS  = 6'h1F;

  localparam logic [NUM_CFG-1:0][AW-1:0] CFG_ADDR = {6'h12, 6'h11, 6'h10};
  localparam logic [NUM_CFG-1:0][DW-1:0] CFG_MASK = {16'h0777, 16'h0FFF, 16'h01FF};
  localparam logic [NUM_CFG-1:0][DW-1:0] CFG_RST  = {16'h0777, 16'h0000, 16'h0115};

  localparam logic [2:0] SYS_KEY = 3'b101;
  localparam int LOCK_POS = 7;
  localparam int PEN_POS  = 6;
  localparam int POR_POS  = 7;
endpackage

// File: rtl/grb_wr_decode.sv
module grb_wr_decode
  import grb_pkg::*;
(
  input  logic               wr_en,
  input  addr_t              addr,
  input  logic [2:0]         key,
  input  logic               cmd_bit,
  input  logic               locked,
  output logic [NUM_CFG-1:0] cfg_we,
  output logic               sys_we,
  output logic               clr_req
);
  for (genvar i = 0; i < NUM_CFG; i++) begin : g_we
    assign cfg_we[i] = wr_en && !locked && (addr == CFG_ADDR[i]);
  end

  assign sys_we  = wr_en && (addr == ADR_SYS) && (key == SYS_KEY);
  assign clr_req = wr_en && (addr == ADR_CMD) && cmd_bit;
endmodule

// File: rtl/grb_cfg_bank.sv
module grb_cfg_bank
  import grb_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CFG-1:0]          cfg_we,
  input  word_t                       wdata,
  output logic [NUM_CFG-1:0][DW-1:0]  cfg_q
);
  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    word_t nxt;

    always_comb begin
      nxt = cfg_q[i];
      if (cfg_we[i]) nxt = wdata & CFG_MASK[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= CFG_RST[i];
      else        cfg_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/grb_ctrl_state.sv
module grb_ctrl_state (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_we,
  input  logic lock_wr,
  input  logic pen_wr,
  input  logic clr_req,
  output logic lock_q,
  output logic pen_q,
  output logic por_q,
  output logic clr_q
);
  logic lock_d, pen_d, por_d, clr_d;

  always_comb begin
    lock_d = lock_q;
    pen_d  = pen_q;
    if (sys_we) begin
      lock_d = lock_wr;
      pen_d  = pen_wr;
    end
    por_d = clr_req ? 1'b0 : por_q;
    clr_d = clr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      pen_q  <= 1'b0;
      por_q  <= 1'b1;
      clr_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      pen_q  <= pen_d;
      por_q  <= por_d;
      clr_q  <= clr_d;
    end
  end
endmodule

// File: rtl/grb_rd_port.sv
module grb_rd_port
  import grb_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  addr_t                       addr,
  input  logic [NUM_CFG-1:0][DW-1:0]  cfg_q,
  input  logic [DEV_W-1:0]            dev_flags,
  input  logic [TEMP_W-1:0]           temp_flags,
  input  logic [DRV_W-1:0]            drv_flags,
  input  logic                        por,
  input  logic                        lock,
  input  logic                        pen,
  output word_t                       rdata_q
);
  word_t sel, framed, rdata_d;

  always_comb begin
    sel = '0;
    case (addr)
      ADR_DEV: begin
        sel[DEV_W-1:0] = dev_flags;
        sel[POR_POS]   = por;
      end
      ADR_TEMP: sel[TEMP_W-1:0] = temp_flags;
      ADR_DRV:  sel[DRV_W-1:0]  = drv_flags;
      ADR_SYS: begin
        sel[LOCK_POS] = lock;
        sel[PEN_POS]  = pen;
      end
      default: sel = '0;
    endcase
    for (int i = 0; i < NUM_CFG; i++) begin
      if (addr == CFG_ADDR[i]) sel = cfg_q[i];
    end
  end

  always_comb begin
    framed         = sel;
    framed[DW-1]   = pen ? ^sel[DW-2:0] : 1'b0;
    rdata_d        = rd_en ? framed : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
endmodule

// File: rtl/guarded_regbank.sv
module guarded_regbank
  import grb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  input  logic [DEV_W-1:0]          stat_dev_i,
  input  logic [TEMP_W-1:0]         stat_temp_i,
  input  logic [DRV_W-1:0]          stat_drv_i,
  output logic [NUM_CFG*DW-1:0]     cfg_o,
  output logic                      lock_o,
  output logic                      par_en_o,
  output logic                      clr_pulse_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_CFG-1:0]         cfg_we;
  logic                       sys_we, clr_req;
  logic [NUM_CFG-1:0][DW-1:0] cfg_q;
  logic                       lock_q, pen_q, por_q, clr_q;

  grb_wr_decode u_dec (
    .wr_en   (wr_en),
    .addr    (addr),
    .key     (wdata[14:12]),
    .cmd_bit (wdata[0]),
    .locked  (lock_q),
    .cfg_we  (cfg_we),
    .sys_we  (sys_we),
    .clr_req (clr_req)
  );

  grb_cfg_bank u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cfg_we (cfg_we),
    .wdata  (wdata),
    .cfg_q  (cfg_q)
  );

  grb_ctrl_state u_ctl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sys_we  (sys_we),
    .lock_wr (wdata[LOCK_POS]),
    .pen_wr  (wdata[PEN_POS]),
    .clr_req (clr_req),
    .lock_q  (lock_q),
    .pen_q   (pen_q),
    .por_q   (por_q),
    .clr_q   (clr_q)
  );

  grb_rd_port u_rd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_en      (rd_en),
    .addr       (addr),
    .cfg_q      (cfg_q),
    .dev_flags  (stat_dev_i),
    .temp_flags (stat_temp_i),
    .drv_flags  (stat_drv_i),
    .por        (por_q),
    .lock       (lock_q),
    .pen        (pen_q),
    .rdata_q    (rdata)
  );

  assign cfg_o       = cfg_q;
  assign lock_o      = lock_q;
  assign par_en_o    = pen_q;
  assign clr_pulse_o = clr_q;
endmodule

// File: rtl/grb_checker.sv
module grb_checker
  import grb_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [AW-1:0]         addr,
  input logic [2:0]            key,
  input logic                  cmd_bit,
  input logic [DW-1:0]         rdata,
  input logic [NUM_CFG*DW-1:0] cfg_o,
  input logic                  lock_o,
  input logic                  par_en_o,
  input logic                  clr_pulse_o
);
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse_o |=> !clr_pulse_o); // R7

  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse_o |-> $past(wr_en && addr == ADR_CMD && cmd_bit)); // R7

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> $stable(cfg_o)); // R6

  AST_KEY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_SYS && key != SYS_KEY) |=> ($stable(lock_o) && $stable(par_en_o))); // R5

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && par_en_o) |=> (^rdata == 1'b0)); // R8

  AST_PAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !par_en_o) |=> !rdata[DW-1]); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R9
endmodule

bind guarded_regbank grb_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .key         (wdata[14:12]),
  .cmd_bit     (wdata[0]),
  .rdata       (rdata),
  .cfg_o       (cfg_o),
  .lock_o      (lock_o),
  .par_en_o    (par_en_o),
  .clr_pulse_o (clr_pulse_o)
);

// File: tb/sim_guarded_regbank.sv
`timescale 1ns/1ps
module sim_guarded_regbank;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en;
  logic [5:0]  addr;
  logic [15:0] wdata, rdata;
  logic [6:0]  stat_dev_i;
  logic [2:0]  stat_temp_i;
  logic [5:0]  stat_drv_i;
  logic [47:0] cfg_o;
  logic        lock_o, par_en_o, clr_pulse_o;

  int total = 0;
  int bad   = 0;
  bit pe    = 1'b0;
  bit pend  = 1'b0;
  bit done  = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  guarded_regbank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .stat_dev_i(stat_dev_i),
    .stat_temp_i(stat_temp_i), .stat_drv_i(stat_drv_i), .cfg_o(cfg_o),
    .lock_o(lock_o), .par_en_o(par_en_o), .clr_pulse_o(clr_pulse_o)
  );

  function automatic logic [15:0] frame(input logic [15:0] w, input bit p);
    return p ? {^w[14:0], w[14:0]} : {1'b0, w[14:0]};
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] raw, input string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(frame(raw, pe));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) pend <= rd_en && rst_n;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 unexpected read data act=%h exp=none", rdata);
      end else begin
        chk(tag_q.pop_front(), {32'h0, rdata}, {32'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    stat_dev_i = '0; stat_temp_i = '0; stat_drv_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    chk("R1 rdata", {32'h0, rdata}, 48'h0);
    chk("R1 lock", {47'h0, lock_o}, 48'h0);
    chk("R1 par_en", {47'h0, par_en_o}, 48'h0);
    chk("R1 clr", {47'h0, clr_pulse_o}, 48'h0);
    chk("R1 cfg_o", cfg_o, {16'h0777, 16'h0000, 16'h0115});
    rd(6'h10, 16'h0115, "R1 cfg0");
    rd(6'h11, 16'h0000, "R1 cfg1");
    rd(6'h12, 16'h0777, "R1 cfg2");
    rd(6'h1F, 16'h0000, "R1 sys");
    rd(6'h00, 16'h0080, "R7 por after reset");

    // R2 masking
    wr(6'h11, 16'hFFFF);
    rd(6'h11, 16'h0FFF, "R2 cfg1 mask");
    wr(6'h10, 16'hABCD);
    rd(6'h10, 16'h01CD, "R2 cfg0 mask");
    chk("R2 cfg_o", cfg_o, {16'h0777, 16'h0FFF, 16'h01CD});

    // R3 live status
    stat_dev_i = 7'h55; stat_temp_i = 3'h5; stat_drv_i = 6'h2A;
    rd(6'h00, 16'h00D5, "R3 dev");
    rd(6'h01, 16'h0005, "R3 temp");
    rd(6'h02, 16'h002A, "R3 drv");

    // R10 status read-only
    wr(6'h00, 16'hFFFF);
    wr(6'h02, 16'h0000);
    rd(6'h00, 16'h00D5, "R10 dev after write");
    rd(6'h02, 16'h002A, "R10 drv after write");

    // R4 unmapped
    wr(6'h05, 16'h1234);
    rd(6'h05, 16'h0000, "R4 unmapped 05");
    rd(6'h3F, 16'h0000, "R4 unmapped 3F");
    chk("R4 cfg_o untouched", cfg_o, {16'h0777, 16'h0FFF, 16'h01CD});

    // R5 key protection
    wr(6'h1F, 16'h00C0);
    chk("R5 no key lock", {47'h0, lock_o}, 48'h0);
    chk("R5 no key pen", {47'h0, par_en_o}, 48'h0);
    rd(6'h1F, 16'h0000, "R5 sys after keyless write");
    wr(6'h1F, 16'h5040);
    pe = 1'b1;
    chk("R5 keyed pen", {47'h0, par_en_o}, 48'h1);

    // R8 parity on, odd and even words
    rd(6'h1F, 16'h0040, "R8 R5 sys key reads 0 with parity");
    rd(6'h11, 16'h0FFF, "R8 even word");
    rd(6'h00, 16'h00D5, "R8 odd word");

    // R6 lock
    wr(6'h1F, 16'h50C0);
    chk("R6 lock set", {47'h0, lock_o}, 48'h1);
    wr(6'h12, 16'h0000);
    rd(6'h12, 16'h0777, "R6 locked write ignored");
    chk("R6 cfg_o frozen", cfg_o, {16'h0777, 16'h0FFF, 16'h01CD});

    // R7 clear command while locked
    wr(6'h18, 16'h0001);
    chk("R7 pulse high", {47'h0, clr_pulse_o}, 48'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", {47'h0, clr_pulse_o}, 48'h0);
    rd(6'h00, 16'h0055, "R7 por cleared");
    rd(6'h18, 16'h0000, "R7 cmd reads 0");
    wr(6'h18, 16'h0000);
    chk("R7 no pulse on 0", {47'h0, clr_pulse_o}, 48'h0);

    // R6 unlock with key, parity off
    wr(6'h1F, 16'h5000);
    pe = 1'b0;
    chk("R6 unlocked", {47'h0, lock_o}, 48'h0);
    wr(6'h12, 16'hF123);
    rd(6'h12, 16'h0123, "R6 R2 write after unlock");
    rd(6'h00, 16'h0055, "R8 parity off");

    // R9 hold between reads
    rd(6'h01, 16'h0005, "R9 temp read");
    stat_temp_i = 3'h2;
    repeat (2) @(negedge clk);
    chk("R9 rdata holds", {32'h0, rdata}, {32'h0, 16'h0005});
    rd(6'h01, 16'h0002, "R9 temp new");

    repeat (3) @(negedge clk);
    chk("R9 queue drained", {16'h0, 32'(exp_q.size())}, 48'h0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule